// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands, eight bits each by default, and returns the full double-width product. Every partial-product bit is formed by an AND gate, and all of them are formed together before any addition. The bits of equal weight are then summed column by column. Each column adds its own partial products and the carries that arrive from lower columns. It keeps one bit and sends its upper sum bits on toward higher weights.

The heavy columns are reduced by 4:2 compressor cells. Three rows of these cells are chained into a seven-input reducer, which brings seven shifted partial-product rows down to one sum vector and one carry vector. Any rows left over are folded in by full-adder rows, and a single carry-propagate add then gives the product. The arithmetic path has no clock. A parameter adds one output register, with synchronous active-low reset, to help timing; the register changes no result.

Top module: `mulc_top`

## Requirements
- R1: For every pair of 8-bit unsigned operands, the 16-bit output equals the exact integer product A×B.
- R2: Partial product bit (i,j) is A[i] AND B[j] and carries weight 2^(i+j), so operands 2^i and 2^j give a product with only bit i+j set.
- R3: Each 4:2 cell keeps arithmetic weight: x1+x2+x3+x4+cin = sum + 2·(carry+cout). Its cout depends only on x1, x2 and x3, so it never ripples.
- R4: The seven-input reducer returns a sum vector and a carry vector whose total, modulo 2^16, equals the total of its seven input rows.
- R5: If either operand is zero, the product is zero.
- R6: The top product bit comes out of the carry chain, not from A[7]·B[7] alone. It is set exactly when A×B ≥ 32768, for example 0xFF×0x81 = 0x807F and 0xFF×0xFF = 0xFE01.
- R7: With the output register enabled (the default), the product appears at the first rising clock edge after the operands are applied. While rst_n is low at a rising edge, the output clears to zero, whatever the operands are.
- R8: An operand of one passes the other operand through unchanged, zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a_i | input | N (8) | Unsigned multiplicand |
| b_i | input | N (8) | Unsigned multiplier |
| prod_o | output | 2N (16) | Unsigned product |

## Verification
Some checks run on every evaluation. Each compressor cell checks that it keeps arithmetic weight, and the seven-input reducer checks that it keeps the total of its rows. On every clock edge the registered output is compared with the product of the previous cycle's operands, and there are separate checks for the zero-operand and identity cases. The register needs the bench's scenarios to show its timing: the output holds before the capturing edge, and a reset asserted in mid-run overrides non-zero operands. The bench also sweeps the full operand space and all one-hot operand pairs, which shows that every column's carries are routed to the right weight.

// File: rtl/mulc_pkg.sv
// Shared helpers for the compressor-tree multiplier.
// Assumes: nothing beyond plain combinational logic.
package mulc_pkg;

    // Default operand width
    localparam int unsigned OPW_DEF = 8;

    // Majority of three bits: the carry of a full adder
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

endpackage

// File: rtl/mulc_cmp42.sv
// One 4:2 compressor cell: four equal-weight bits plus a carry-in are reduced
// to a sum of the same weight and two bits (carry, cout) of double weight.
// Assumes: cout is passed sideways to the next column's cin by the caller.
module mulc_cmp42
    import mulc_pkg::*;
(
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic x4,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);

    logic s1;

    // First level: a full adder over x1..x3, whose cout does not depend on cin
    assign s1   = x1 ^ x2 ^ x3;
    assign cout = maj3(x1, x2, x3);

    // Second level: fold in x4 and the carry arriving from the column below
    assign sum   = s1 ^ x4 ^ cin;
    assign carry = maj3(s1, x4, cin);

    // Check that the cell keeps its inputs' arithmetic weight (R3)
    always_comb begin
        p_weight_kept_r3: assert (3'(x1) + 3'(x2) + 3'(x3) + 3'(x4) + 3'(cin)
                                  == 3'(sum) + 3'(2) * (3'(carry) + 3'(cout)))
            else $error("4:2 cell lost weight");
    end

endmodule

// File: rtl/mulc_row42.sv
// A row of W 4:2 cells that reduces four W-bit vectors to a sum vector and a
// carry vector. Each cell's cout feeds the next column's cin.
// Assumes: results are used modulo 2^W, so bits carried past the top are dropped.
module mulc_row42 #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] va,
    input  logic [W-1:0] vb,
    input  logic [W-1:0] vc,
    input  logic [W-1:0] vd,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    logic [W:0]   side;
    logic [W-1:0] car;
    logic         spill_unused;

    // Column 0 has no carry arriving from below
    assign side[0] = 1'b0;

    // One compressor cell for each column
    for (genvar k = 0; k < W; k++) begin : g_col
        mulc_cmp42 u_cell (
            .x1   (va[k]),
            .x2   (vb[k]),
            .x3   (vc[k]),
            .x4   (vd[k]),
            .cin  (side[k]),
            .sum  (s_o[k]),
            .carry(car[k]),
            .cout (side[k+1])
        );
    end

    // Carry bits have double weight, so they shift up by one column
    assign c_o = {car[W-2:0], 1'b0};

    // Bits past the top column fall outside the modulo-2^W result
    assign spill_unused = car[W-1] ^ side[W];

endmodule

// File: rtl/mulc_row72.sv
// Seven-input reducer: three cascaded 4:2 rows bring seven W-bit vectors down
// to one sum vector and one carry vector. The third row's spare input is zero.
// Assumes: all vectors are already aligned to their weight.
module mulc_row72 #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] v0,
    input  logic [W-1:0] v1,
    input  logic [W-1:0] v2,
    input  logic [W-1:0] v3,
    input  logic [W-1:0] v4,
    input  logic [W-1:0] v5,
    input  logic [W-1:0] v6,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    logic [W-1:0] s1, c1, s2, c2;

    // Stage 1: reduce the first four rows
    mulc_row42 #(.W(W)) u_st1 (.va(v0), .vb(v1), .vc(v2), .vd(v3), .s_o(s1), .c_o(c1));
    // Stage 2: combine the stage 1 pair with rows four and five
    mulc_row42 #(.W(W)) u_st2 (.va(s1), .vb(c1), .vc(v4), .vd(v5), .s_o(s2), .c_o(c2));
    // Stage 3: combine the stage 2 pair with row six
    mulc_row42 #(.W(W)) u_st3 (.va(s2), .vb(c2), .vc(v6), .vd('0), .s_o(s_o), .c_o(c_o));

    // Check that the reducer keeps the total of its inputs modulo 2^W (R4)
    always_comb begin
        p_total_kept_r4: assert (W'(v0 + v1 + v2 + v3 + v4 + v5 + v6) == W'(s_o + c_o))
            else $error("seven-input reducer lost its total");
    end

endmodule

// File: rtl/mulc_top.sv
// Unsigned N x N multiplier. An AND array forms every partial product at once.
// A seven-input compressor reducer takes the first seven rows, full-adder rows
// fold in any rows left over, and one carry-propagate add gives the product.
// The top bit comes out of that final carry.
// Assumes: N >= 7. OUT_REG=1 adds one output register with synchronous
// active-low reset.
module mulc_top #(
    parameter int unsigned N       = mulc_pkg::OPW_DEF,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     a_i,
    input  logic [N-1:0]     b_i,
    output logic [2*N-1:0]   prod_o
);

    localparam int unsigned W     = 2 * N;
    localparam int unsigned XROWS = N - 7;

    logic [W-1:0] pp [N];
    logic [W-1:0] ss [XROWS+1];
    logic [W-1:0] cc [XROWS+1];
    logic [W-1:0] comb_prod;

    // Full-adder row over three vectors: the sum vector
    function automatic logic [W-1:0] fa_s(input logic [W-1:0] x, y, z);
        return x ^ y ^ z;
    endfunction

    // Full-adder row over three vectors: the carry vector, shifted to double weight
    function automatic logic [W-1:0] fa_c(input logic [W-1:0] x, y, z);
        return ((x & y) | (x & z) | (y & z)) << 1;
    endfunction

    // AND array: row r is A gated by B[r], placed at weight 2^r
    for (genvar r = 0; r < N; r++) begin : g_pp
        assign pp[r] = W'(a_i & {N{b_i[r]}}) << r;
    end

    // Compress the first seven rows
    mulc_row72 #(.W(W)) u_red (
        .v0(pp[0]), .v1(pp[1]), .v2(pp[2]), .v3(pp[3]),
        .v4(pp[4]), .v5(pp[5]), .v6(pp[6]),
        .s_o(ss[0]), .c_o(cc[0])
    );

    // Fold each row left over into the sum/carry pair
    for (genvar t = 0; t < XROWS; t++) begin : g_extra
        assign ss[t+1] = fa_s(ss[t], cc[t], pp[7+t]);
        assign cc[t+1] = fa_c(ss[t], cc[t], pp[7+t]);
    end

    // Final carry-propagate add; it also produces the top product bit
    assign comb_prod = ss[XROWS] + cc[XROWS];

    if (OUT_REG) begin : g_reg
        logic [W-1:0] prod_q;

        // Output register, cleared by the synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= comb_prod;
        end
        assign prod_o = prod_q;

        // Registered product equals last cycle's true product
        p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> prod_o == W'($past(a_i)) * W'($past(b_i)))
            else $error("product mismatch");
        // A zero operand yields zero
        p_zero_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (a_i == '0 || b_i == '0) |=> prod_o == '0)
            else $error("zero operand gave non-zero product");
        // An operand of one passes the other through
        p_identity_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (a_i == N'(1)) |=> prod_o == W'($past(b_i)))
            else $error("identity operand failed");
    end else begin : g_comb
        assign prod_o = comb_prod;
    end

endmodule

// File: tb/mulc_top_tb.sv
`timescale 1ns/1ps
module mulc_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic [15:0] prod_o;
    int          n_chk = 0;
    int          n_fail = 0;

    // Each entry is {a, b, expected product}
    localparam logic [31:0] VEC [10] = '{
        {8'hFF, 8'hFF, 16'hFE01},   // R6 top bit from carries; R3 R4 all cells busy
        {8'hFF, 8'h81, 16'h807F},   // R6 just above 2^15
        {8'h7F, 8'h7F, 16'h3F01},   // R6 top bit clear
        {8'h80, 8'h80, 16'h4000},   // R2 single partial product
        {8'h00, 8'hA5, 16'h0000},   // R5
        {8'h5A, 8'h00, 16'h0000},   // R5
        {8'h01, 8'hC3, 16'h00C3},   // R8
        {8'hC3, 8'h01, 16'h00C3},   // R8
        {8'h0F, 8'hF0, 16'h0E10},   // R4 mixed columns
        {8'hAA, 8'h55, 16'h3872}    // R4 alternating bits
    };

    mulc_top u_dut (.clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .prod_o(prod_o));

    // 125 MHz clock
    always #4 clk = ~clk;

    // Compare one observed value and record the result
    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive operands away from the edge, then sample just after the capturing edge
    task automatic apply(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        a_i = a;
        b_i = b;
        @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R7: reset clears the output even with non-zero operands
        a_i = 8'hFF;
        b_i = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset state", prod_o, 16'h0000);

        // R7: output holds until the capturing edge, then shows the product
        @(negedge clk);
        rst_n = 1'b1;
        a_i = 8'd3;
        b_i = 8'd5;
        #1;
        check("R7 before edge", prod_o, 16'h0000);
        @(posedge clk);
        #1;
        check("R7 after one edge", prod_o, 16'd15);

        // Table of directed vectors
        for (int i = 0; i < 10; i++) begin
            apply(VEC[i][31:24], VEC[i][23:16]);
            check("R1 R2 R3 R4 R5 R6 R8 vector", prod_o, VEC[i][15:0]);
        end

        // R2: one-hot operands set exactly bit i+j
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                apply(8'(1 << i), 8'(1 << j));
                check("R2 one-hot", prod_o, 16'(1 << (i + j)));
            end
        end

        // R1: every operand pair against a reference multiply
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply(8'(a), 8'(b));
                check("R1 exhaustive", prod_o, 16'(a * b));
            end
        end

        // R7: reset asserted mid-run overrides non-zero operands
        apply(8'hFF, 8'hFF);
        check("R7 pre-reset value", prod_o, 16'hFE01);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R7 mid-run reset", prod_o, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R7 after reset release", prod_o, 16'hFE01);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule